// File: doc/BRIEF.md
# Bit-Serial Two-Operand Adder

This block adds two WIDTH-bit operands (four bits by default) with one full adder, working on one bit position per clock. The first operand sits in a register that shifts right. The second operand sits in a register that rotates right. On each step the full adder takes the least significant bit of each register and the stored carry. The sum bit drops into the top of the first register. The carry goes back into a single flip-flop.

After WIDTH effective steps the first register holds the sum, the flip-flop holds the carry out of the top bit, and the second register has rotated back to its starting value. A one-cycle completion pulse marks that point.

The controls are plain level pins:
- Separate load pulses fill each operand register and preset the carry, so an operation starts with any initial carry.
- A step enable advances the computation and can be dropped at any time to pause it.
- There is no valid/ready handshake. The block does not stream data: the caller owns the timing completely, and a held step enable is the only form of stall.

Top module: `bitser_adder`

## Requirements
- R1: While rst_n is low, the result register, the second-operand register and the carry flip-flop clear to zero, and done is low.
- R2: A cycle with opa_ld high puts opa_d on acc_q after the next clock edge. A cycle with opb_ld high puts opb_d on opb_q after the next clock edge.
- R3: A cycle with cy_ld high puts cy_d on cy_q after the next clock edge.
- R4: An effective step shifts the result register right by one bit, and the new top bit (bit WIDTH-1) is the full-adder sum of acc_q[0], opb_q[0] and cy_q.
- R5: An effective step rotates opb_q right by one bit, so the old bit 0 becomes bit WIDTH-1. After WIDTH effective steps opb_q equals its loaded value.
- R6: On an effective step cy_q takes the full-adder carry, which is 1 when at least two of acc_q[0], opb_q[0] and cy_q are 1.
- R7: Start from a load of A, B and initial carry c0, then make WIDTH effective steps, in any number of cycles. Afterwards acc_q equals (A+B+c0) mod 2^WIDTH and cy_q equals bit WIDTH of A+B+c0.
- R8: done goes high for exactly one cycle after every WIDTH-th effective step counted since the last cy_ld or reset, and stays low at all other times.
- R9: In a cycle with step_en low and no load, acc_q, opb_q, cy_q and the step count keep their values.
- R10: A step is effective only when step_en is high and opa_ld, opb_ld and cy_ld are all low. In a cycle with any load, no register shifts and the step count does not advance. Only the loaded registers change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opa_ld | input | 1 | Load first operand into the result register |
| opa_d | input | WIDTH | First operand value |
| opb_ld | input | 1 | Load second operand register |
| opb_d | input | WIDTH | Second operand value |
| cy_ld | input | 1 | Preset carry flip-flop and restart the step count |
| cy_d | input | 1 | Initial carry value |
| step_en | input | 1 | Request one bit-serial step |
| acc_q | output | WIDTH | Result register (operand A before, sum after) |
| cy_q | output | 1 | Carry flip-flop (final carry after the last step) |
| opb_q | output | WIDTH | Second operand register |
| done | output | 1 | One-cycle pulse after the last step of an operation |

## Verification
The bench sweeps every operand pair with both initial carries. This exposes a sum bit entering the wrong end of the register, a carry used one position late, and a carry missed on propagate-only chains such as 1111+0000+1; any of these would give wrong sums on a subset of the pairs. Some operations pause the step enable mid-operation. A design that counted cycles instead of effective steps would pulse done early there and leave a partial sum. Single-step checks catch B shifting instead of rotating, which would leave B zero-filled at the end. Checks with a load and the step enable asserted together catch a step that is not blocked by the load, which would move the other registers.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

  typedef enum logic [1:0] {
    REG_HOLD  = 2'd0,
    REG_LOAD  = 2'd1,
    REG_SHIFT = 2'd2
  } reg_op_e;

  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  function automatic logic fa_cout(input logic x, input logic y, input logic ci);
    return (x & y) | (ci & (x ^ y));
  endfunction

endpackage

// File: rtl/bsa_shreg.sv
module bsa_shreg
  import bsa_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit ROTATE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  reg_op_e          op,
  input  logic [WIDTH-1:0] d_in,
  input  logic             ser_in,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    unique case (op)
      REG_LOAD:  q_nxt = d_in;
      REG_SHIFT: q_nxt = {ser_in, q[WIDTH-1:1]};
      default:   q_nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op == REG_LOAD |=> q == $past(d_in));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op == REG_HOLD |=> $stable(q));

  p_shift_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op == REG_SHIFT |=> q[WIDTH-2:0] == $past(q[WIDTH-1:1]));

  generate
    if (ROTATE) begin : g_rot_chk
      p_rotate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op == REG_SHIFT |=> q[WIDTH-1] == $past(q[0]));
    end
  endgenerate

endmodule

// File: rtl/bsa_carry.sv
module bsa_carry
  import bsa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic init_val,
  input  logic step,
  input  logic a_bit,
  input  logic b_bit,
  output logic sum_bit,
  output logic c_q
);

  logic c_nxt;

  assign sum_bit = fa_sum(a_bit, b_bit, c_q);

  always_comb begin
    if (init)      c_nxt = init_val;
    else if (step) c_nxt = fa_cout(a_bit, b_bit, c_q);
    else           c_nxt = c_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) c_q <= 1'b0;
    else        c_q <= c_nxt;
  end

  p_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> c_q == $past(init_val));

  p_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !init) |=> c_q == ($countones({$past(a_bit), $past(b_bit), $past(c_q)}) >= 2));

  p_carry_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !init) |=> $stable(c_q));

endmodule

// File: rtl/bsa_seq.sv
module bsa_seq #(
  parameter int WIDTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic step,
  output logic done
);

  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (restart) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (step) begin
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
      done <= (cnt == LAST);
    end else begin
      done <= 1'b0;
    end
  end

  p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(step) && !$past(restart)));

  p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !restart) |=> $stable(cnt));

endmodule

// File: rtl/bitser_adder.sv
module bitser_adder
  import bsa_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             opa_ld,
  input  logic [WIDTH-1:0] opa_d,
  input  logic             opb_ld,
  input  logic [WIDTH-1:0] opb_d,
  input  logic             cy_ld,
  input  logic             cy_d,
  input  logic             step_en,
  output logic [WIDTH-1:0] acc_q,
  output logic             cy_q,
  output logic [WIDTH-1:0] opb_q,
  output logic             done
);

  logic    any_ld;
  logic    eff_step;
  logic    sum_bit;
  reg_op_e op_a;
  reg_op_e op_b;

  assign any_ld   = opa_ld | opb_ld | cy_ld;
  assign eff_step = step_en & ~any_ld;

  always_comb begin
    if (opa_ld)        op_a = REG_LOAD;
    else if (eff_step) op_a = REG_SHIFT;
    else               op_a = REG_HOLD;

    if (opb_ld)        op_b = REG_LOAD;
    else if (eff_step) op_b = REG_SHIFT;
    else               op_b = REG_HOLD;
  end

  bsa_shreg #(.WIDTH(WIDTH), .ROTATE(1'b0)) u_areg (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op_a),
    .d_in   (opa_d),
    .ser_in (sum_bit),
    .q      (acc_q)
  );

  bsa_shreg #(.WIDTH(WIDTH), .ROTATE(1'b1)) u_breg (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op_b),
    .d_in   (opb_d),
    .ser_in (opb_q[0]),
    .q      (opb_q)
  );

  bsa_carry u_cy (
    .clk      (clk),
    .rst_n    (rst_n),
    .init     (cy_ld),
    .init_val (cy_d),
    .step     (eff_step),
    .a_bit    (acc_q[0]),
    .b_bit    (opb_q[0]),
    .sum_bit  (sum_bit),
    .c_q      (cy_q)
  );

  bsa_seq #(.WIDTH(WIDTH)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (cy_ld),
    .step    (eff_step),
    .done    (done)
  );

  p_sum_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !any_ld) |=> acc_q[WIDTH-1] ==
      ($past(acc_q[0]) ^ $past(opb_q[0]) ^ $past(cy_q)));

  p_ld_blocks_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !opa_ld && (opb_ld || cy_ld)) |=> $stable(acc_q));

  p_ld_blocks_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !opb_ld && (opa_ld || cy_ld)) |=> $stable(opb_q));

endmodule

// File: tb/sim_bitser_adder.sv
module sim_bitser_adder;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         opa_ld, opb_ld, cy_ld, cy_d, step_en;
  logic [W-1:0] opa_d, opb_d;
  logic [W-1:0] acc_q, opb_q;
  logic         cy_q, done;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit fin   = 1'b0;
  bit mon_en = 1'b0;

  logic [W:0]   q_res[$];
  logic [W-1:0] q_b[$];
  logic [W:0]   m_res;
  logic [W-1:0] m_b;

  always #4 clk = ~clk;

  bitser_adder #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .opa_ld(opa_ld), .opa_d(opa_d),
    .opb_ld(opb_ld), .opb_d(opb_d),
    .cy_ld(cy_ld), .cy_d(cy_d),
    .step_en(step_en),
    .acc_q(acc_q), .cy_q(cy_q), .opb_q(opb_q), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!fin) begin
      fin = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // monitor: pops the scoreboard on every completion pulse
  always @(negedge clk) begin
    if (mon_en && done) begin
      if (q_res.size() == 0) begin
        n_chk++;
        n_err++;
        $display("FAIL R8: unexpected done pulse, actual=1 expected=0");
      end else begin
        m_res = q_res.pop_front();
        m_b   = q_b.pop_front();
        check("R7 sum", 32'(acc_q), 32'(m_res[W-1:0]));
        check("R7 carry", 32'(cy_q), 32'(m_res[W]));
        check("R5 operand B restored", 32'(opb_q), 32'(m_b));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !fin) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cyc);
      finish_run();
    end
  end

  // driver: one full operation, optional pause in the middle
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic c, input bit stall);
    @(negedge clk);
    opa_ld = 1'b1; opa_d = a;
    opb_ld = 1'b1; opb_d = b;
    cy_ld  = 1'b1; cy_d  = c;
    step_en = 1'b0;
    q_res.push_back({1'b0, a} + {1'b0, b} + {{W{1'b0}}, c});
    q_b.push_back(b);
    @(negedge clk);
    opa_ld = 1'b0; opb_ld = 1'b0; cy_ld = 1'b0;
    step_en = 1'b1;
    for (int k = 0; k < W; k++) begin
      if (stall && k == 2) begin
        step_en = 1'b0;
        @(negedge clk);
        step_en = 1'b1;
      end
      @(negedge clk);
    end
    step_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    opa_ld = 1'b0; opb_ld = 1'b0; cy_ld = 1'b0; cy_d = 1'b0;
    step_en = 1'b0; opa_d = '0; opb_d = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 acc", 32'(acc_q), 32'h0);
    check("R1 opb", 32'(opb_q), 32'h0);
    check("R1 carry", 32'(cy_q), 32'h0);
    check("R1 done", 32'(done), 32'h0);
    rst_n = 1'b1;

    // R2/R3: loads
    @(negedge clk);
    opa_ld = 1'b1; opa_d = 4'b0011;
    opb_ld = 1'b1; opb_d = 4'b0001;
    cy_ld = 1'b1;  cy_d = 1'b1;
    @(negedge clk);
    opa_ld = 1'b0; opb_ld = 1'b0; cy_ld = 1'b0;
    check("R2 load A", 32'(acc_q), 32'h3);
    check("R2 load B", 32'(opb_q), 32'h1);
    check("R3 carry preset", 32'(cy_q), 32'h1);

    // R4/R5/R6: one step, 1+1+1 -> sum 1, carry 1
    step_en = 1'b1;
    @(negedge clk);
    step_en = 1'b0;
    check("R4 shift with sum in MSB", 32'(acc_q), 32'h9);
    check("R5 rotate B", 32'(opb_q), 32'h8);
    check("R6 carry out", 32'(cy_q), 32'h1);
    check("R8 no early done", 32'(done), 32'h0);

    // R9: idle cycle holds everything
    @(negedge clk);
    check("R9 hold acc", 32'(acc_q), 32'h9);
    check("R9 hold B", 32'(opb_q), 32'h8);
    check("R9 hold carry", 32'(cy_q), 32'h1);

    // R10: load with step request blocks the step
    step_en = 1'b1; opb_ld = 1'b1; opb_d = 4'h5;
    @(negedge clk);
    opb_ld = 1'b0;
    check("R10 B loaded not shifted", 32'(opb_q), 32'h5);
    check("R10 acc unchanged", 32'(acc_q), 32'h9);
    check("R10 carry unchanged", 32'(cy_q), 32'h1);
    cy_ld = 1'b1; cy_d = 1'b0;
    @(negedge clk);
    cy_ld = 1'b0; step_en = 1'b0;
    check("R10 acc unchanged on carry preset", 32'(acc_q), 32'h9);
    check("R10 B unchanged on carry preset", 32'(opb_q), 32'h5);
    check("R3 carry preset to zero", 32'(cy_q), 32'h0);
    check("R8 done low", 32'(done), 32'h0);

    // R7/R8/R5: full sweep through the scoreboard
    mon_en = 1'b1;
    for (int c = 0; c < 2; c++) begin
      for (int a = 0; a < (1 << W); a++) begin
        for (int b = 0; b < (1 << W); b++) begin
          run_op(W'(a), W'(b), c[0], ((a + b) % 5) == 0);
        end
      end
    end
    @(negedge clk);
    @(negedge clk);
    check("R8 every operation completed once", 32'(q_res.size()), 32'h0);
    finish_run();
  end

endmodule